// File: doc/BRIEF.md
# Empty-Only Dual-Clock FIFO

This block carries data words from a producer clock domain into an unrelated consumer clock domain. It is meant for high-speed paths where the surrounding system already guarantees that the buffer never overfills. That guarantee lets the block drop all fill-side status. A write is accepted on every cycle that requests one, and the only flag is the read-side `empty`.

Each side keeps a binary pointer and derives a Gray-coded copy of it. The write pointer's Gray copy crosses into the read clock through a two-stage synchronizer. The read side compares its next Gray pointer with that synchronized value and registers the result as `empty`. The read pointer never leaves the read domain.

Pointers are log2(DEPTH) bits wide, with no extra wrap bit. As a result, at most DEPTH-1 words may be outstanding at any time. The read port is first-word-fall-through: while `empty` is low, `rd_data` already shows the oldest word, and `rd_en` consumes it.

Top module: `egf_fifo`

## Requirements
- R1: Between consecutive write-clock edges, the Gray-coded write pointer changes in at most one bit position, including when it wraps from DEPTH-1 back to 0.
- R2: Every write-clock edge with `wr_en` high stores `wr_data` and advances the write pointer by one. No write is ever refused.
- R3: A `rd_en` at a read-clock edge where `empty` is high is ignored. The read pointer holds, so the next word written is the next word read.
- R4: With both resets held low at a clock edge, `empty` is high afterwards, and the first word written after reset is the first word read.
- R5: While `empty` is low, `rd_data` shows the oldest unread word, and a read-clock edge with `rd_en` high consumes it. `empty` rises at the same edge that consumes the last stored word.
- R6: After a write into an empty FIFO, `empty` stays high after the first and second read-clock edges that follow the write edge, and goes low after the third.
- R7: Words come out in write order for every fill level from 1 to DEPTH-1 words, from any starting pointer position, including across the pointer wrap.
- R8: Writes and reads running at the same time, in unrelated clocks, deliver every word once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain synchronous reset, active low |
| wr_en | input | 1 | Store `wr_data` at this edge |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain synchronous reset, active low |
| rd_en | input | 1 | Consume the word on `rd_data` at this edge |
| rd_data | output | DATA_W | Oldest unread word, valid while `empty` is low |
| empty | output | 1 | No unread word is visible to the read side |

## Verification
The bench first fills the FIFO with every level from one word up to DEPTH-1 words and then drains it. It runs this sweep twice, so that bursts start at many pointer offsets and cross the wrap. Losing the top fill level, or breaking the wrap, therefore shows up as a wrong word or a wrong flag.

A single write into an empty FIFO is timed edge by edge on the read clock. This separates a correct two-stage synchronizer from one that is too short or too long.

Reads issued while the FIFO is empty are followed by a fresh write. This shows whether the read pointer slipped.

A final phase runs a producer and a consumer at the same time in unrelated clocks. It exposes ordering or duplication faults that only appear while the pointers move together.

// File: rtl/egf_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the empty-only dual-clock FIFO.
// Assumes pointer widths are set by the instantiating module.
package egf_pkg;
    // Binary to reflected Gray conversion.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/egf_store.sv
`timescale 1ns/1ps
// Dual-port storage array: written on wr_clk, read combinationally by address.
// Assumes the read address only points at words whose write has already
// been made visible through the pointer synchronizer.
module egf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Present the addressed word to the read port.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/egf_wr_ptr.sv
`timescale 1ns/1ps
// Write-side pointer: binary address for the array plus a registered Gray copy
// for crossing. No fill detection; the system keeps at most DEPTH-1 words queued.
module egf_wr_ptr #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_gray
);
    import egf_pkg::*;

    logic [AW-1:0] bin_q, bin_d;
    logic [AW-1:0] gray_q;

    // Next binary pointer: step on every write request.
    always_comb begin
        bin_d = bin_q + AW'(wr_en);
    end

    // Pointer registers with synchronous active-low reset.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= AW'(bin2gray(32'(bin_d)));
        end
    end

    assign wr_addr = bin_q;
    assign wr_gray = gray_q;

    // R1
    gray_one_bit_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $past(wr_rst_n) |-> ($countones(gray_q ^ $past(gray_q)) <= 1));

    // R2
    wr_advance_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |=> (bin_q == AW'($past(bin_q) + 1'b1)));
endmodule

// File: rtl/egf_sync2.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded bus into the destination clock.
// Assumes the source changes at most one bit per source clock edge.
module egf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, stable_q;

    // Capture then re-register to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/egf_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side control: read pointer and registered empty flag.
// Empty compares the next read Gray pointer with the synchronized write Gray
// pointer. Assumes the writer never gets DEPTH words ahead.
module egf_rd_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] wgray_sync,
    output logic [AW-1:0] rd_addr,
    output logic          empty
);
    import egf_pkg::*;

    logic [AW-1:0] bin_q, bin_d;
    logic [AW-1:0] gray_d;
    logic          empty_q;
    logic          take;

    // Next pointer: advance only on an accepted read.
    always_comb begin
        take   = rd_en & ~empty_q;
        bin_d  = bin_q + AW'(take);
        gray_d = AW'(bin2gray(32'(bin_d)));
    end

    // Pointer and flag registers with synchronous active-low reset.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            bin_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            bin_q   <= bin_d;
            empty_q <= (gray_d == wgray_sync);
        end
    end

    assign rd_addr = bin_q;
    assign empty   = empty_q;

    // R3
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && empty_q) |=> $stable(bin_q));

    // R5
    empty_rise_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(rd_rst_n) && $rose(empty_q) |-> $past(rd_en));
endmodule

// File: rtl/egf_fifo.sv
`timescale 1ns/1ps
// Empty-only dual-clock FIFO top. Writes are always accepted; the system must
// keep at most DEPTH-1 words outstanding. DEPTH must be a power of two.
// First-word-fall-through read port.
module egf_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_addr, wr_gray, wgray_sync, rd_addr;

    egf_wr_ptr #(.DEPTH(DEPTH)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_gray  (wr_gray)
    );

    egf_sync2 #(.W(AW)) u_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wgray_sync)
    );

    egf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_en      (rd_en),
        .wgray_sync (wgray_sync),
        .rd_addr    (rd_addr),
        .empty      (empty)
    );

    egf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .raddr  (rd_addr),
        .rdata  (rd_data)
    );
endmodule

// File: tb/egf_fifo_bench.sv
`timescale 1ns/1ps
module egf_fifo_bench;
    localparam int DW = 16;
    localparam int DP = 16;

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic empty;

    int checks = 0, errors = 0;
    int wcnt = 0, rcnt = 0;
    bit done = 0;

    always #5    wr_clk = ~wr_clk;
    always #6.5  rd_clk = ~rd_clk;

    egf_fifo #(.DATA_W(DW), .DEPTH(DP)) u_egf_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty)
    );

    function automatic logic [DW-1:0] val(input int k);
        return DW'(k * 40503 + 4660);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_one();
        @(negedge wr_clk);
        wr_en = 1; wr_data = val(wcnt);
        @(posedge wr_clk);
        #1 wr_en = 0;
        wcnt++;
    endtask

    task automatic read_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            chk(!empty, "R5 not empty", empty, 0);
            chk(rd_data == val(rcnt), "R7 order", rd_data, val(rcnt));
            rd_en = 1;
            @(posedge rd_clk);
            #0.2 rd_en = 0;
            rcnt++;
        end
        @(negedge rd_clk);
        chk(empty, "R5 empty after last", empty, 1);
    endtask

    initial begin
        repeat (4) @(posedge rd_clk);
        #0.2;
        // R4 reset state
        chk(empty, "R4 reset empty", empty, 1);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (2) @(posedge rd_clk);

        // R4 first word after reset comes out first
        write_one();
        repeat (5) @(posedge rd_clk);
        read_burst(1);

        // R7 / R2 sweep of every fill level, twice for offset variety
        for (int pass = 0; pass < 2; pass++) begin
            for (int n = 1; n < DP; n++) begin
                for (int i = 0; i < n; i++) write_one();
                repeat (5) @(posedge rd_clk);
                #0.2;
                chk(!empty, "R2 writes visible", empty, 0);
                read_burst(n);
            end
        end

        // R6 latency of a single write into an empty FIFO
        @(negedge wr_clk);
        wr_en = 1; wr_data = val(wcnt);
        @(posedge wr_clk);
        fork begin #1 wr_en = 0; end join_none
        wcnt++;
        for (int e = 1; e <= 3; e++) begin
            @(posedge rd_clk);
            #0.2;
            chk(empty == (e < 3), "R6 empty latency", empty, (e < 3));
        end
        read_burst(1);

        // R3 reads while empty are ignored
        @(negedge rd_clk);
        rd_en = 1;
        repeat (4) @(posedge rd_clk);
        #0.2 rd_en = 0;
        chk(empty, "R3 still empty", empty, 1);
        write_one();
        repeat (5) @(posedge rd_clk);
        read_burst(1);

        // R8 concurrent traffic
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    write_one();
                    @(negedge wr_clk);
                end
            end
            begin
                int target;
                target = rcnt + 40;
                while (rcnt < target) begin
                    @(negedge rd_clk);
                    if (!empty) begin
                        chk(rd_data == val(rcnt), "R8 concurrent order", rd_data, val(rcnt));
                        rd_en = 1;
                        rcnt++;
                    end
                    @(posedge rd_clk);
                    #0.2 rd_en = 0;
                end
            end
        join
        repeat (6) @(posedge rd_clk);
        #0.2;
        chk(empty, "R8 drained", empty, 1);
        chk(rcnt == wcnt, "R8 count", rcnt, wcnt);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule